// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

The block keeps a 32-bit free-running counter that moves forward by one on every clock cycle in which the count-enable tick input is high. It has four 32-bit compare registers. When a tick moves the counter onto the value held in a compare register, that channel records a pending event, but only if its interrupt enable bit is set. A pending event drives the channel's interrupt output. Software sees the pending events in a status register. It clears them by writing ones, and the clear also drops the matching interrupt lines.

Channel 3 has a second role as a one-shot watchdog. Suppose bit 0 of the watchdog-arm register is set when channel 3 matches. The block then asserts a reset-request pulse for one cycle and clears the arm register, so the watchdog does not fire again until software re-arms it. A simple 32-bit bus reaches every register. A write takes effect at the next clock edge. A read is combinational on the address.

Each channel is a two-state machine: `CH_IDLE` moves to `CH_PEND` on an enabled match, and `CH_PEND` moves back to `CH_IDLE` on a write-one clear that does not coincide with a new enabled match. The watchdog machine has three states:

| From | To | Condition |
|---|---|---|
| `WD_OFF` | `WD_ARMED` | A write to the arm register with bit 0 set |
| `WD_ARMED` | `WD_FIRE` | A channel-3 match |
| `WD_ARMED` | `WD_OFF` | A write with bit 0 clear |
| `WD_FIRE` | `WD_ARMED` | A re-arming write in the same cycle |
| `WD_FIRE` | `WD_OFF` | Otherwise |

`WD_FIRE` lasts one cycle and drives the reset request.

Top module: `tmr_match_wdog`

## Requirements
- R1: After reset, every register reads as zero, all four interrupt outputs are low and the reset request is low.
- R2: Each clock cycle with `tick` high and no counter write adds one to the counter, and the counter wraps from 0xFFFFFFFF to 0. Cycles with `tick` low leave the counter unchanged.
- R3: A write to the counter (offset 0x10) loads the written value in place of that cycle's tick, and counting continues from the loaded value. Loading a value equal to a compare register does not count as a match.
- R4: A tick that moves the counter onto channel i's compare value (offset 0x00 + 4·i) is a match. Channel i has interrupt enable bit i at offset 0x1C. If that bit is 1, status bit i sets and `irq[i]` rises in the cycle after that tick. If the bit is 0, nothing is recorded.
- R5: Status bits 3..0 sit at offset 0x14. Writing there clears each bit written as 1 and lowers its `irq` line from the next cycle, and bits written as 0 are left unchanged. When an enabled match and a clear of the same channel fall in one cycle, the match wins and the bit stays set.
- R6: The interrupt enable register (offset 0x1C) stores only its low 12 bits, and bits 31..12 read back as 0.
- R7: When bit 0 of the watchdog-arm register (offset 0x18) is set at the moment channel 3 matches, `reset_req` is high for exactly the next cycle and the arm register then reads 0. This happens whatever the interrupt enable bit 3 holds. With bit 0 clear, a channel-3 match produces no reset request.
- R8: Reads return the stored compare and arm values, the live counter value and the status bits with bits 31..4 at 0. Reads of any unmapped offset return 0.
- R9: Matching is on equality only. A compare value the counter has already passed fires only after the counter wraps through zero and reaches it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable: the counter advances in each cycle this is high |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines, high while the status bit is set |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
A channel machine stuck in `CH_PEND`, or one that fails to leave `CH_IDLE`, shows at its `irq` pin one cycle after the clear or match that should have moved it. The reference model compares the interrupt lines and the reset request on every clock, so such a fault is reported at the first cycle it becomes visible. A wrong counter value shows only at its next read, or as a match that arrives a cycle early or late, or never. For that reason the bench reads the counter back right after loads, wraps and idle stretches. A watchdog machine left in `WD_ARMED` shows as an arm register that still reads 1 after firing, or as a second pulse on a later channel-3 match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MATCH0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WDARM  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h1C;

    typedef enum logic {
        CH_IDLE,
        CH_PEND
    } chan_state_e;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_ARMED,
        WD_FIRE
    } wd_state_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    match_we,
    output logic              cnt_we,
    output logic              stat_we,
    output logic              wdarm_we,
    output logic              ien_we
);
    for (genvar i = 0; i < NCH; i++) begin : g_match_we
        assign match_we[i] = wr_en && (addr == OFS_MATCH0 + ADDR_W'(4 * i));
    end

    assign cnt_we   = wr_en && (addr == OFS_COUNT);
    assign stat_we  = wr_en && (addr == OFS_STATUS);
    assign wdarm_we = wr_en && (addr == OFS_WDARM);
    assign ien_we   = wr_en && (addr == OFS_IEN);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cnt_next,
    output logic          advance
);
    // A load replaces the tick of the same cycle.
    assign advance  = tick && !load;
    assign cnt_next = cnt_q + DW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (advance) begin
            cnt_q <= cnt_next;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_we,
    input  logic [DW-1:0] wdata,
    input  logic          advance,
    input  logic [DW-1:0] cnt_next,
    input  logic          enable,
    input  logic          clear,
    output logic [DW-1:0] cmp_q,
    output logic          hit,
    output logic          pend
);
    chan_state_e state_q, state_d;
    logic        rec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_we) begin
            cmp_q <= wdata;
        end
    end

    // Only the tick that produces the equal value counts.
    assign hit = advance && (cnt_next == cmp_q);
    assign rec = hit && enable;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (rec)            state_d = CH_PEND;
            CH_PEND: if (clear && !rec)  state_d = CH_IDLE;
            default:                     state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pend = (state_q == CH_PEND);
    end
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_we,
    input  logic [DW-1:0] wdata,
    input  logic          hit,
    output logic [DW-1:0] arm_q,
    output logic          fire
);
    wd_state_e state_q, state_d;
    logic      trip;

    assign trip = (state_q == WD_ARMED) && hit;

    // The trip clears the arm register and wins over a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (trip) begin
            arm_q <= '0;
        end else if (arm_we) begin
            arm_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (arm_we && wdata[0]) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (hit)                      state_d = WD_FIRE;
                else if (arm_we && !wdata[0]) state_d = WD_OFF;
            end
            WD_FIRE: begin
                if (arm_we && wdata[0]) state_d = WD_ARMED;
                else                    state_d = WD_OFF;
            end
            default: state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fire = (state_q == WD_FIRE);
    end
endmodule

// File: rtl/tmr_match_wdog.sv
module tmr_match_wdog
    import tmr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 4,
    parameter int IEW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    irq,
    output logic              reset_req
);
    localparam int WD_CH = NCH - 1;

    logic [NCH-1:0] match_we;
    logic           cnt_we;
    logic           stat_we;
    logic           wdarm_we;
    logic           ien_we;
    logic [DW-1:0]  cnt_q;
    logic [DW-1:0]  cnt_next;
    logic           advance;
    logic [DW-1:0]  cmp_q [NCH];
    logic [NCH-1:0] chan_hit;
    logic [NCH-1:0] pend;
    logic [IEW-1:0] ien_q;
    logic [DW-1:0]  arm_q;

    tmr_decode #(.NCH(NCH)) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .match_we (match_we),
        .cnt_we   (cnt_we),
        .stat_we  (stat_we),
        .wdarm_we (wdarm_we),
        .ien_we   (ien_we)
    );

    tmr_counter #(.DW(DW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_we),
        .load_val (wdata),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .advance  (advance)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tmr_channel #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmp_we   (match_we[i]),
            .wdata    (wdata),
            .advance  (advance),
            .cnt_next (cnt_next),
            .enable   (ien_q[i]),
            .clear    (stat_we && wdata[i]),
            .cmp_q    (cmp_q[i]),
            .hit      (chan_hit[i]),
            .pend     (pend[i])
        );
    end

    tmr_watchdog #(.DW(DW)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_we (wdarm_we),
        .wdata  (wdata),
        .hit    (chan_hit[WD_CH]),
        .arm_q  (arm_q),
        .fire   (reset_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_we) begin
            ien_q <= wdata[IEW-1:0];
        end
    end

    assign irq = pend;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == OFS_MATCH0 + ADDR_W'(4 * i)) rdata = cmp_q[i];
        end
        if (addr == OFS_COUNT)  rdata = cnt_q;
        if (addr == OFS_STATUS) rdata = DW'(pend);
        if (addr == OFS_WDARM)  rdata = arm_q;
        if (addr == OFS_IEN)    rdata = DW'(ien_q);
    end
endmodule

// File: rtl/tmr_match_wdog_chk.sv
module tmr_match_wdog_chk
    import tmr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 4,
    parameter int IEW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [NCH-1:0]    irq,
    input logic              reset_req,
    input logic [DW-1:0]     cnt_q,
    input logic [NCH-1:0]    chan_hit,
    input logic [IEW-1:0]    ien_q
);
    logic cnt_wr;
    logic st_wr;
    assign cnt_wr = wr_en && (addr == OFS_COUNT);
    assign st_wr  = wr_en && (addr == OFS_STATUS);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt_q == $past(cnt_q) + DW'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wdata)));

    assert_enabled_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_hit & ien_q[NCH-1:0]) != '0)
        |=> ((irq & $past(chan_hit & ien_q[NCH-1:0])) == $past(chan_hit & ien_q[NCH-1:0])));

    assert_disabled_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_hit & ~ien_q[NCH-1:0] & ~irq) != '0)
        |=> ((irq & $past(chan_hit & ~ien_q[NCH-1:0] & ~irq)) == '0));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((irq & $past(wdata[NCH-1:0] & ~(chan_hit & ien_q[NCH-1:0]))) == '0));

    assert_fire_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_fire_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(chan_hit[NCH-1]));
endmodule

bind tmr_match_wdog tmr_match_wdog_chk #(.DW(DW), .NCH(NCH), .IEW(IEW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .reset_req (reset_req),
    .cnt_q     (cnt_q),
    .chan_hit  (chan_hit),
    .ien_q     (ien_q)
);

// File: tb/tmr_match_wdog_test.sv
module tmr_match_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        reset_req;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_match_wdog uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq),
        .reset_req (reset_req)
    );

    // Behavioural reference model.
    logic [31:0] m_cnt;
    logic [31:0] m_cmp [4];
    logic [3:0]  m_stat;
    logic [31:0] m_arm;
    logic [31:0] m_ien;
    logic        m_rst;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_stat = '0; m_arm = '0; m_ien = '0; m_rst = 1'b0;
            for (int i = 0; i < 4; i++) m_cmp[i] = '0;
        end else begin
            logic [3:0]  h;
            logic [31:0] nx;
            logic        ld;
            logic [3:0]  ien_old;
            logic        armed_old;
            ld = wr_en && addr == 8'h10;
            nx = m_cnt + 32'd1;
            for (int i = 0; i < 4; i++) h[i] = tick && !ld && (nx == m_cmp[i]);
            ien_old = m_ien[3:0];
            armed_old = m_arm[0];
            if (wr_en) begin
                case (addr)
                    8'h00: m_cmp[0] = wdata;
                    8'h04: m_cmp[1] = wdata;
                    8'h08: m_cmp[2] = wdata;
                    8'h0C: m_cmp[3] = wdata;
                    8'h10: m_cnt = wdata;
                    8'h14: m_stat = m_stat & ~wdata[3:0];
                    8'h18: m_arm = wdata;
                    8'h1C: m_ien = wdata & 32'h0000_0FFF;
                    default: ;
                endcase
            end
            if (!ld && tick) m_cnt = nx;
            m_stat = m_stat | (h & ien_old);
            m_rst = h[3] && armed_old;
            if (m_rst) m_arm = '0;
        end
        #2;
        check("R4 irq per-cycle", {28'd0, irq}, {28'd0, m_stat});
        check("R7 reset_req per-cycle", {31'd0, reset_req}, {31'd0, m_rst});
        if (reset_req) pulses++;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; tick = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic step(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1 check(tag, rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) rd("R1 reset register", 8'(4 * i), 32'h0);
        check("R1 reset irq", {28'd0, irq}, 32'h0);
        check("R1 reset request", {31'd0, reset_req}, 32'h0);

        // R6: enable register width
        wr(8'h1C, 32'hFFFF_F00F);
        rd("R6 enable keeps low 12 bits", 8'h1C, 32'h0000_000F);

        // R4, R8: first match
        wr(8'h00, 32'd5);
        rd("R8 compare readback", 8'h00, 32'd5);
        step(4);
        check("R4 no irq before match", {28'd0, irq}, 32'h0);
        step(1);
        check("R4 irq after match", {28'd0, irq}, 32'h1);
        rd("R8 status read", 8'h14, 32'h1);
        rd("R2 counter after ticks", 8'h10, 32'd5);
        step(3);
        idle(3);
        rd("R2 counter holds without tick", 8'h10, 32'd8);

        // R5: write-one-to-clear
        wr(8'h14, 32'h0);
        check("R5 zero write keeps bit", {28'd0, irq}, 32'h1);
        wr(8'h14, 32'h1);
        check("R5 one write clears bit", {28'd0, irq}, 32'h0);

        // R4: disabled channel records nothing
        wr(8'h1C, 32'h0000_000E);
        wr(8'h10, 32'd20);
        wr(8'h00, 32'd22);
        step(2);
        rd("R4 disabled match not recorded", 8'h14, 32'h0);

        // R3: loading the compare value does not fire
        wr(8'h1C, 32'h0000_000F);
        wr(8'h10, 32'd22);
        idle(1);
        rd("R3 load equal to compare no fire", 8'h14, 32'h0);
        step(1);
        rd("R3 count continues from load", 8'h10, 32'd23);

        // R2: wrap, channels 1..3 hold 0 and match at the wrap
        wr(8'h10, 32'hFFFF_FFFE);
        step(3);
        rd("R2 wrap count", 8'h10, 32'd1);
        rd("R2 wrap matches zero compares", 8'h14, 32'hE);
        wr(8'h14, 32'hF);

        // R9: passed compare fires only after wrap
        wr(8'h08, 32'd10);
        wr(8'h10, 32'd30);
        step(5);
        rd("R9 passed compare silent", 8'h14, 32'h0);
        wr(8'h10, 32'hFFFF_FFF0);
        step(25);
        check("R9 not yet at compare", {31'd0, irq[2]}, 32'h0);
        step(1);
        check("R9 fires after wrap", {31'd0, irq[2]}, 32'h1);
        wr(8'h14, 32'hF);

        // R5: match wins over same-cycle clear
        wr(8'h10, 32'd21);
        step(1);
        wr(8'h04, 32'd40);
        wr(8'h10, 32'd39);
        wr_tick(8'h14, 32'h3);
        check("R5 match beats clear", {28'd0, irq}, 32'h2);
        wr(8'h14, 32'hF);

        // R7: watchdog fires once, independent of enable bit 3
        wr(8'h1C, 32'h0000_0007);
        wr(8'h18, 32'h1);
        rd("R8 arm readback", 8'h18, 32'h1);
        wr(8'h0C, 32'd50);
        wr(8'h10, 32'd48);
        p0 = pulses;
        step(1);
        check("R7 no request early", {31'd0, reset_req}, 32'h0);
        step(1);
        check("R7 request after match", {31'd0, reset_req}, 32'h1);
        idle(1);
        #1 check("R7 request one cycle", {31'd0, reset_req}, 32'h0);
        rd("R7 arm cleared", 8'h18, 32'h0);
        check("R7 disabled ch3 no irq", {31'd0, irq[3]}, 32'h0);
        check("R7 single pulse", pulses - p0, 32'd1);

        // R7: disarmed watchdog stays quiet
        wr(8'h18, 32'h2);
        wr(8'h10, 32'd48);
        p0 = pulses;
        step(3);
        idle(2);
        check("R7 disarmed no request", pulses - p0, 32'd0);
        rd("R8 arm stored value", 8'h18, 32'h2);

        // R8: map
        rd("R8 compare 3", 8'h0C, 32'd50);
        rd("R8 compare 2", 8'h08, 32'd10);
        rd("R8 unmapped", 8'h24, 32'h0);
        rd("R8 unmapped 0x20", 8'h20, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule